// File: doc/BRIEF.md
# Triggered sampling stop controller

This block sequences a circular analog sample store. While armed, it writes one cell per main clock, with the address wrapping around the store. A discriminator trigger does not freeze the store at once. After a programmable number of further clocks, writing stops, so the store holds samples from both before and after the trigger. All timing is referenced to the main clock, and no sub-clock interpolation is done.

When the trigger is accepted, the block latches a coarse timestamp from a free-running clock counter. When writing stops, it records the address of the last cell written. It then enters a read phase. The read address starts at the oldest stored cell and advances one cell per clock, so the downstream converter receives the samples in time order. An external read-done input ends the read phase and returns the block to idle, where it can be armed again.

Top module: `trig_stop_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, the outputs are as follows: `wr_en` and `busy` are 0, and `wr_addr`, `rd_addr`, `stop_addr` and `tstamp` are all 0.
- R2: While `wr_en` is high, `wr_addr` advances by one on every clock and wraps from 2^AW-1 to 0.
- R3: `trig_in` passes through a two-stage synchronizer followed by a rising-edge detector. A trigger level held high is accepted only once. Only an edge that arrives while the block is writing and not yet triggered is used.
- R4: Suppose `delay` = D ≥ 1 at the accepted edge. Then `wr_en` stays high for D clocks after the edge cycle and falls on the clock after that.
- R5: With `delay` = 0, `wr_en` is low on the cycle that follows the edge cycle.
- R6: `tstamp` takes the value of a free-running counter during the edge cycle. This counter is 0 on the first cycle after reset and increases by one every clock. `tstamp` holds its value until the next accepted edge.
- R7: `stop_addr` takes the value of the last address written before writing stops.
- R8: In the read phase, `rd_addr` starts at `stop_addr`+1 modulo 2^AW and advances by one every clock, wrapping.
- R9: `busy` rises on the cycle after the edge cycle. It stays high through the delay and read phases and falls on the clock after `rd_done` is sampled high in the read phase. Triggers and changes of `arm` while `busy` is high have no effect.
- R10: In idle with `arm` low, nothing is written. Dropping `arm` while writing with no trigger returns the block to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Enables continuous writing |
| trig_in | input | 1 | Asynchronous discriminator trigger |
| delay | input | DW | Post-trigger clocks before writing stops |
| rd_done | input | 1 | Ends the read phase |
| wr_en | output | 1 | Store write enable |
| wr_addr | output | AW | Store write address |
| rd_addr | output | AW | Store read address |
| stop_addr | output | AW | Last cell written |
| tstamp | output | TW | Coarse trigger timestamp |
| busy | output | 1 | Trigger accepted and read-out not finished |

## Verification
The assertions assume that `delay` and `rd_done` are driven from the clock domain of the block, and that only `trig_in` may change at any time. The stimulus changes every input just after a falling edge, so none of them changes near the active edge. Trigger pulses last several clocks, which keeps each one visible to the synchronizer. Extra trigger pulses and changes of `arm` are injected while the block is busy, to show that they are ignored without breaking these assumptions.

// File: rtl/trig_stop_ctrl.sv
module trig_stop_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig_in,
  input  logic [DW-1:0] delay,
  input  logic          rd_done,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] stop_addr,
  output logic [TW-1:0] tstamp,
  output logic          busy
);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_DELAY, S_READ} st_t;

  st_t           st;
  logic [2:0]    sync;
  logic [DW-1:0] cnt;
  logic [TW-1:0] ts_cnt;
  logic          edge_det, stop_now;

  assign edge_det = sync[1] & ~sync[2];
  assign wr_en    = (st == S_WRITE) || (st == S_DELAY);
  assign busy     = (st == S_DELAY) || (st == S_READ);
  assign stop_now = (st == S_WRITE && edge_det && delay == '0) ||
                    (st == S_DELAY && cnt == DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sync      <= '0;
      cnt       <= '0;
      ts_cnt    <= '0;
      tstamp    <= '0;
      wr_addr   <= '0;
      rd_addr   <= '0;
      stop_addr <= '0;
    end else begin
      ts_cnt <= ts_cnt + 1'b1;
      sync   <= {sync[1:0], trig_in};
      if (wr_en)       wr_addr <= wr_addr + 1'b1;
      if (st == S_READ) rd_addr <= rd_addr + 1'b1;
      case (st)
        S_IDLE:  if (arm) st <= S_WRITE;
        S_WRITE: begin
          if (edge_det) begin
            tstamp <= ts_cnt;
            if (delay != '0) begin
              cnt <= delay;
              st  <= S_DELAY;
            end
          end else if (!arm) begin
            st <= S_IDLE;
          end
        end
        S_DELAY: cnt <= cnt - 1'b1;
        S_READ:  if (rd_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (stop_now) begin
        stop_addr <= wr_addr;
        rd_addr   <= wr_addr + 1'b1;
        st        <= S_READ;
      end
    end
  end

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_addr == AW'($past(wr_addr) + 1'b1));

  a_r4_delay_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DELAY) |-> cnt != '0);

  a_r8_read_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_READ) |-> rd_addr == AW'(stop_addr + 1'b1));

  a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && !rd_done) |=> rd_addr == AW'($past(rd_addr) + 1'b1));

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_done) |=> busy);

  a_r6_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_done) |=> $stable(tstamp));

endmodule

// File: tb/trig_stop_ctrl_bench.sv
module trig_stop_ctrl_bench;
  localparam int AW = 8, DW = 8, TW = 16;

  logic clk = 0, rst_n = 0, arm = 0, trig_in = 0, rd_done = 0;
  logic [DW-1:0] delay = '0;
  logic wr_en, busy;
  logic [AW-1:0] wr_addr, rd_addr, stop_addr;
  logic [TW-1:0] tstamp;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trig_stop_ctrl #(.AW(AW), .DW(DW), .TW(TW)) u_trig_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_in(trig_in), .delay(delay),
    .rd_done(rd_done), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .stop_addr(stop_addr), .tstamp(tstamp), .busy(busy));

  // Reference model built from the requirements: 0 idle, 1 write, 2 delay, 3 read
  int m_ph = 0;
  logic [2:0] m_sy = '0;
  logic [DW-1:0] m_left = '0;
  logic [TW-1:0] m_clk = '0, m_ts = '0;
  logic [AW-1:0] m_wa = '0, m_ra = '0, m_sa = '0;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_sy = '0; m_left = '0; m_clk = '0; m_ts = '0;
      m_wa = '0; m_ra = '0; m_sa = '0;
    end else begin
      automatic bit rise = m_sy[1] && !m_sy[2];
      automatic bit writing = (m_ph == 1 || m_ph == 2);
      automatic bit last = 0;
      case (m_ph)
        0: if (arm) m_ph = 1;
        1: if (rise) begin
             m_ts = m_clk;
             if (delay == 0) last = 1; else begin m_left = delay; m_ph = 2; end
           end else if (!arm) m_ph = 0;
        2: begin if (m_left == 1) last = 1; m_left = m_left - 1'b1; end
        3: begin m_ra = nxt(m_ra); if (rd_done) m_ph = 0; end
        default: m_ph = 0;
      endcase
      if (last) begin m_sa = m_wa; m_ra = nxt(m_wa); m_ph = 3; end
      if (writing) m_wa = nxt(m_wa);
      m_clk = m_clk + 1'b1;
      m_sy = {m_sy[1:0], trig_in};
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4", "wr_en", wr_en, (m_ph == 1 || m_ph == 2));
    chk("R9", "busy", busy, (m_ph == 2 || m_ph == 3));
    chk("R2", "wr_addr", wr_addr, m_wa);
    chk("R8", "rd_addr", rd_addr, m_ra);
    chk("R7", "stop_addr", stop_addr, m_sa);
    chk("R6", "tstamp", tstamp, m_ts);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected<150000 cycles", wd);
      finish_run();
    end
  end

  // one capture: count write cycles after the trigger rise (edge cycle + D + 1 pipeline)
  task automatic capture(input int pre, input int dly, input int width, input int rlen, input bit noise);
    int n = 0;
    arm = 1; delay = DW'(dly);
    cyc(pre);
    trig_in = 1;
    while (1) begin
      @(negedge clk);
      if (n + 1 == width) trig_in = 0;
      if (!wr_en) break;
      n++;
      if (noise && n == 3) arm = 0;
    end
    trig_in = 0;
    if (dly == 0) chk("R5", "write cycles after trigger", n, 2);
    else          chk("R4", "write cycles after trigger", n, dly + 2);
    chk("R9", "busy when frozen", busy, 1);
    if (noise) begin trig_in = 1; cyc(4); trig_in = 0; end
    cyc(rlen);
    rd_done = 1; cyc(1); rd_done = 0;
    chk("R9", "busy after read done", busy, 0);
    arm = 0;
    cyc(2);
  endtask

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    chk("R1", "wr_en in reset", wr_en, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "wr_addr after reset", wr_addr, 0);
    chk("R1", "tstamp after reset", tstamp, 0);
    cyc(5);
    chk("R10", "no write while unarmed", wr_en, 0);
    arm = 1; cyc(300);
    chk("R2", "wr_addr wrapped", wr_addr, 299 % 256);
    arm = 0; cyc(2);
    chk("R10", "idle after arm drop", wr_en, 0);
    capture(5, 0, 2, 10, 0);
    capture(5, 1, 2, 10, 0);
    capture(7, 2, 3, 300, 1);
    capture(4, 255, 2, 5, 0);
    // held trigger accepted once
    arm = 1; delay = 3; cyc(4); trig_in = 1;
    cyc(12); rd_done = 1; cyc(1); rd_done = 0;
    cyc(10);
    chk("R3", "held trigger not re-accepted", busy, 0);
    chk("R3", "writing resumed", wr_en, 1);
    trig_in = 0; arm = 0; cyc(3);
    for (int i = 0; i < 80; i++) begin
      automatic int sel = $urandom_range(0, 3);
      automatic int d = (sel == 0) ? 0 : (sel == 1) ? 1 : $urandom_range(2, 40);
      capture($urandom_range(0, 30), d, $urandom_range(1, 6), $urandom_range(0, 40), $urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) begin
        rst_n = 0; cyc(2); rst_n = 1; cyc(1);
      end
    end
    finish_run();
  end
endmodule